// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block maintains the two error counters of a CAN node, one for transmission and one for reception, and decides from them which of three fault confinement states the node is in. The bit stream logic reports what happened on the bus as single-cycle pulses: a transmit error, a receive error, a receive error where a dominant bit followed the node's own error flag, a good transmission and a good reception. Each pulse adjusts the matching counter. The new counter values are compared with fixed passive and bus-off thresholds, and with a warning limit that the host can change.

State, warning level and three interrupt pulses are presented to the host. Once the node is in bus off, it ignores all error and success events. It stays in bus off until the host has left its initialisation mode and the bus logic has reported 128 separate runs of eleven recessive bits. At that point both counters clear and the node is error active again.

Top module: `fcsm_top`

## Requirements
- R1: A `tx_err` pulse raises the transmit count by 8 at the next clock edge.
- R2: A `rx_err` pulse raises the receive count by 1, and a `rx_err_dom` pulse raises it by 8. When both arrive in the same cycle, the count rises by 8 only.
- R3: A `tx_ok` or `rx_ok` pulse lowers the matching count by 1. A count of 0 stays at 0.
- R4: When an error pulse and a success pulse for the same counter arrive in the same cycle, only the error is applied.
- R5: The state code is 2'b01 (passive) while either count is above 127 and the transmit count is 255 or less. It is 2'b00 (active) when both counts are 127 or less. The code 2'b11 never occurs.
- R6: The state code becomes 2'b10 (bus off) in the edge where the transmit count goes above 255. While in bus off, both counts stay unchanged and error and success pulses have no effect.
- R7: `err_warn` is high when either count is greater than or equal to the warning limit. The limit resets to 96. A `lim_wr` pulse loads `lim_din`, and the new limit applies to the warning level from the edge after the write.
- R8: `irq_warn` is high for exactly one cycle, in the same cycle in which `err_warn` changes value.
- R9: `irq_pas` pulses for one cycle on each change between active and passive. `irq_boff` pulses for one cycle on entry to bus off.
- R10: In bus off, `rec11` pulses are counted only while `host_init` is low, and a high `host_init` discards the count made so far. On the 128th counted pulse, both counts become 0 and the state becomes active.
- R11: After reset, both counts are 0, the state is active, `err_warn` and all interrupt pulses are low, and the limit is 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| rx_err_dom | input | 1 | Receive error with dominant bit after own error flag |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| rec11 | input | 1 | Pulse per run of eleven recessive bits |
| host_init | input | 1 | Host holds node in initialisation mode |
| lim_wr | input | 1 | Load strobe for the warning limit |
| lim_din | input | 8 | New warning limit |
| tec | output | 9 | Transmit error count |
| rec | output | 9 | Receive error count |
| state | output | 2 | 00 active, 01 passive, 10 bus off |
| err_warn | output | 1 | Warning level reached |
| irq_warn | output | 1 | Warning level changed pulse |
| irq_pas | output | 1 | Active/passive change pulse |
| irq_boff | output | 1 | Bus-off entry pulse |

## Verification
The checker assumes that each event input is a clean synchronous pulse. It also assumes the limit is not rewritten in the cycle right after another write, so the warning relation is checked only when no write happened in the previous cycle. The increment checks assume the transmit count cannot wrap, which holds because the count stops moving once it passes 255. The bench drives every pulse for exactly one cycle from the falling edge, writes the limit only in isolated cycles, and keeps `host_init` low except during the bus-off recovery scenario.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;

    typedef struct packed {
        fc_state_e st;
        logic      warn;
        logic      irq_w;
        logic      irq_p;
        logic      irq_b;
    } fc_flags_t;

endpackage

// File: rtl/fcsm_errcnt.sv
module fcsm_errcnt #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_one,
    input  logic         inc_step,
    input  logic         dec,
    input  logic         hold,
    input  logic         clr,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx
);
    localparam logic [W:0]   STEP_X = (W+1)'(STEP);
    localparam logic [W-1:0] MAXV   = {W{1'b1}};

    logic [W:0] sum;

    always_comb begin
        cnt_nx = cnt_q;
        sum    = {1'b0, cnt_q} + (inc_step ? STEP_X : (W+1)'(1));
        if (clr) begin
            cnt_nx = '0;
        end else if (!hold) begin
            if (inc_step || inc_one) begin
                cnt_nx = sum[W] ? MAXV : sum[W-1:0];
            end else if (dec && cnt_q != '0) begin
                cnt_nx = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/fcsm_recov.sv
module fcsm_recov #(
    parameter int N = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_boff,
    input  logic host_init,
    input  logic seq11,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          armed;

    always_comb begin
        armed = in_boff && !host_init;
        done  = armed && seq11 && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!armed || done) cnt_d = '0;
        else if (seq11)     cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fcsm_top.sv
module fcsm_top
    import fcsm_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int LIM_W   = 8,
    parameter int LIM_RST = 96,
    parameter int PAS_TH  = 127,
    parameter int BOFF_TH = 255,
    parameter int RECOV_N = 128,
    parameter int ERR_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             rx_err_dom,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             rec11,
    input  logic             host_init,
    input  logic             lim_wr,
    input  logic [LIM_W-1:0] lim_din,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       state,
    output logic             err_warn,
    output logic             irq_warn,
    output logic             irq_pas,
    output logic             irq_boff
);
    localparam logic [CNT_W-1:0] PAS_V  = CNT_W'(PAS_TH);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_TH);

    fc_flags_t        fl_d, fl_q;
    logic [LIM_W-1:0] lim_d, lim_q;
    logic [CNT_W-1:0] tec_nx, rec_nx, lim_x;
    logic             in_boff, rec_done;

    assign in_boff = (fl_q.st == FC_BUSOFF);

    fcsm_errcnt #(.W(CNT_W), .STEP(ERR_STEP)) u_tec (
        .clk(clk), .rst_n(rst_n),
        .inc_one(1'b0), .inc_step(tx_err), .dec(tx_ok),
        .hold(in_boff), .clr(rec_done),
        .cnt_q(tec), .cnt_nx(tec_nx)
    );

    fcsm_errcnt #(.W(CNT_W), .STEP(ERR_STEP)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .inc_one(rx_err), .inc_step(rx_err_dom), .dec(rx_ok),
        .hold(in_boff), .clr(rec_done),
        .cnt_q(rec), .cnt_nx(rec_nx)
    );

    fcsm_recov #(.N(RECOV_N)) u_recov (
        .clk(clk), .rst_n(rst_n),
        .in_boff(in_boff), .host_init(host_init), .seq11(rec11),
        .done(rec_done)
    );

    always_comb begin
        lim_x = CNT_W'(lim_q);
        lim_d = lim_wr ? lim_din : lim_q;
        fl_d  = fl_q;

        if (in_boff) begin
            fl_d.st = rec_done ? FC_ACTIVE : FC_BUSOFF;
        end else if (tec_nx > BOFF_V) begin
            fl_d.st = FC_BUSOFF;
        end else if (tec_nx > PAS_V || rec_nx > PAS_V) begin
            fl_d.st = FC_PASSIVE;
        end else begin
            fl_d.st = FC_ACTIVE;
        end

        fl_d.warn  = (tec_nx >= lim_x) || (rec_nx >= lim_x);
        fl_d.irq_w = (fl_d.warn != fl_q.warn);
        fl_d.irq_p = (fl_d.st != fl_q.st) &&
                     (fl_d.st != FC_BUSOFF) && (fl_q.st != FC_BUSOFF);
        fl_d.irq_b = (fl_d.st == FC_BUSOFF) && (fl_q.st != FC_BUSOFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q  <= '{st: FC_ACTIVE, default: 1'b0};
            lim_q <= LIM_W'(LIM_RST);
        end else begin
            fl_q  <= fl_d;
            lim_q <= lim_d;
        end
    end

    assign state    = fl_q.st;
    assign err_warn = fl_q.warn;
    assign irq_warn = fl_q.irq_w;
    assign irq_pas  = fl_q.irq_p;
    assign irq_boff = fl_q.irq_b;
endmodule

// File: rtl/fcsm_chk.sv
module fcsm_chk #(
    parameter int CNT_W    = 9,
    parameter int LIM_W    = 8,
    parameter int ERR_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err,
    input logic             tx_ok,
    input logic             lim_wr,
    input logic [LIM_W-1:0] lim_q,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic [1:0]       state,
    input logic             err_warn,
    input logic             irq_boff
);
    assert_tx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && state != 2'b10) |=> tec == $past(tec) + CNT_W'(ERR_STEP));

    assert_tx_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok && !tx_err && state == 2'b00 && tec != '0) |=> tec == $past(tec) - CNT_W'(1));

    assert_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b11);

    assert_passive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01) |-> ((tec > CNT_W'(127) || rec > CNT_W'(127)) && tec <= CNT_W'(255)));

    assert_busoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10 && $past(state) == 2'b10) |-> (tec == $past(tec) && rec == $past(rec)));

    assert_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lim_wr) |-> (err_warn == (tec >= CNT_W'(lim_q) || rec >= CNT_W'(lim_q))));

    assert_boff_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_boff |-> (state == 2'b10 && $past(state) != 2'b10));

    assert_recov_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == 2'b10 && state != 2'b10) |-> (state == 2'b00 && tec == '0 && rec == '0));
endmodule

bind fcsm_top fcsm_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W), .ERR_STEP(ERR_STEP)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok),
    .lim_wr(lim_wr), .lim_q(lim_q), .tec(tec), .rec(rec),
    .state(state), .err_warn(err_warn), .irq_boff(irq_boff)
);

// File: tb/fcsm_tb_top.sv
module fcsm_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 0, rx_err = 0, rx_err_dom = 0, tx_ok = 0, rx_ok = 0;
    logic rec11 = 0, host_init = 0, lim_wr = 0;
    logic [7:0] lim_din = '0;
    logic [8:0] tec, rec;
    logic [1:0] state;
    logic err_warn, irq_warn, irq_pas, irq_boff;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fcsm_top dut_i (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
        .rx_err_dom(rx_err_dom), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .rec11(rec11), .host_init(host_init), .lim_wr(lim_wr), .lim_din(lim_din),
        .tec(tec), .rec(rec), .state(state), .err_warn(err_warn),
        .irq_warn(irq_warn), .irq_pas(irq_pas), .irq_boff(irq_boff)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one-cycle pulse: bits {tx_err,rx_err,rx_err_dom,tx_ok,rx_ok,rec11}
    task automatic pulse(input logic [5:0] b);
        @(negedge clk);
        {tx_err, rx_err, rx_err_dom, tx_ok, rx_ok, rec11} = b;
        @(negedge clk);
        {tx_err, rx_err, rx_err_dom, tx_ok, rx_ok, rec11} = '0;
    endtask

    task automatic t_reset;
        chk("R11", "tec", tec, 0);
        chk("R11", "rec", rec, 0);
        chk("R11", "state", state, 0);
        chk("R11", "warn", err_warn, 0);
        chk("R11", "irqs", {irq_warn, irq_pas, irq_boff}, 0);
    endtask

    task automatic t_tx;
        pulse(6'b100000);
        chk("R1", "tec after tx_err", tec, 8);
        pulse(6'b000100);
        chk("R3", "tec after tx_ok", tec, 7);
        for (int i = 0; i < 7; i++) pulse(6'b000100);
        chk("R3", "tec down to zero", tec, 0);
        pulse(6'b000100);
        chk("R3", "tec floor", tec, 0);
        pulse(6'b100100);
        chk("R4", "tec err+ok same cycle", tec, 8);
        for (int i = 0; i < 8; i++) pulse(6'b000100);
        chk("R3", "tec back to zero", tec, 0);
    endtask

    task automatic t_rx;
        for (int i = 0; i < 3; i++) pulse(6'b010000);
        chk("R2", "rec after 3 rx_err", rec, 3);
        pulse(6'b001000);
        chk("R2", "rec after rx_err_dom", rec, 11);
        pulse(6'b000010);
        chk("R3", "rec after rx_ok", rec, 10);
        pulse(6'b011000);
        chk("R2", "rec both errors", rec, 18);
        pulse(6'b010010);
        chk("R4", "rec err+ok same cycle", rec, 19);
        for (int i = 0; i < 19; i++) pulse(6'b000010);
        chk("R3", "rec to zero", rec, 0);
        pulse(6'b000010);
        chk("R3", "rec floor", rec, 0);
    endtask

    task automatic t_warn;
        for (int i = 0; i < 11; i++) pulse(6'b001000);
        chk("R7", "warn below limit", err_warn, 0);
        pulse(6'b001000);
        chk("R7", "warn at 96", err_warn, 1);
        chk("R8", "irq_warn rise", irq_warn, 1);
        @(negedge clk);
        chk("R8", "irq_warn one cycle", irq_warn, 0);
        pulse(6'b000010);
        chk("R7", "warn at 95", err_warn, 0);
        chk("R8", "irq_warn fall", irq_warn, 1);
        @(negedge clk); lim_din = 8'd20; lim_wr = 1;
        @(negedge clk); lim_wr = 0;
        @(negedge clk);
        chk("R7", "warn with limit 20", err_warn, 1);
        @(negedge clk); lim_din = 8'd96; lim_wr = 1;
        @(negedge clk); lim_wr = 0;
        @(negedge clk);
        chk("R7", "warn with limit 96", err_warn, 0);
    endtask

    task automatic t_passive;
        for (int i = 0; i < 4; i++) pulse(6'b001000);
        chk("R5", "active at 127", state, 0);
        pulse(6'b010000);
        chk("R5", "passive at 128", state, 1);
        chk("R9", "irq_pas enter", irq_pas, 1);
        pulse(6'b000010);
        chk("R5", "active again", state, 0);
        chk("R9", "irq_pas leave", irq_pas, 1);
        pulse(6'b010000);
        chk("R5", "passive again", state, 1);
    endtask

    task automatic t_busoff;
        for (int i = 0; i < 31; i++) pulse(6'b100000);
        chk("R1", "tec at 248", tec, 248);
        chk("R5", "still passive", state, 1);
        pulse(6'b100000);
        chk("R6", "bus off", state, 2);
        chk("R6", "tec 256", tec, 256);
        chk("R9", "irq_boff", irq_boff, 1);
        chk("R9", "no irq_pas on bus off", irq_pas, 0);
        @(negedge clk);
        chk("R9", "irq_boff one cycle", irq_boff, 0);
        pulse(6'b100100);
        pulse(6'b011010);
        chk("R6", "tec frozen", tec, 256);
        chk("R6", "rec frozen", rec, 128);
    endtask

    task automatic t_recovery;
        @(negedge clk); host_init = 1;
        for (int i = 0; i < 5; i++) pulse(6'b000001);
        @(negedge clk); host_init = 0;
        for (int i = 0; i < 127; i++) pulse(6'b000001);
        chk("R10", "bus off after 127", state, 2);
        @(negedge clk); host_init = 1;
        @(negedge clk); host_init = 0;
        for (int i = 0; i < 127; i++) pulse(6'b000001);
        chk("R10", "count discarded by host_init", state, 2);
        pulse(6'b000001);
        chk("R10", "active after 128", state, 0);
        chk("R10", "tec cleared", tec, 0);
        chk("R10", "rec cleared", rec, 0);
        chk("R8", "irq_warn on recovery", irq_warn, 1);
        pulse(6'b100000);
        chk("R1", "counts again", tec, 8);
    endtask

    task automatic report;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx();
        t_rx();
        t_warn();
        t_passive();
        t_busoff();
        t_recovery();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule